// File: doc/BRIEF.md
# Card-steering demultiplexer with temperature trim

This block sits between an upstream processor and the per-card serial drivers of an active phased-array antenna. The processor writes one 24-bit DAC command word at a time, strobed by a valid signal, for every DAC chip of every card. It writes all the words of card 0 first, then all the words of card 1, and so on up to the last card. The block does not receive the card number with each word. It keeps a card counter and a slot counter, so it knows which card owns each word as it arrives.

Each word has an 8-bit header and a 16-bit value field. For each word, the block adds the owning card's signed temperature correction to the value field. The correction comes from an external input, one field per card. The sum saturates at the code limits instead of wrapping. The header passes through unchanged. The corrected word then goes to the owning card's registered output bus, together with a valid pulse that lasts one clock cycle. The number of cards is a parameter, and so is the number of DAC chips on each card; the chip counts may differ from card to card.

Top module: `steer_demux_trim`

## Requirements
- R1: Words are assigned to cards in arrival order. Card c receives exactly CHIP_COUNTS[8c+7:8c] consecutive accepted words before the next card starts receiving. A cycle with in_valid low consumes no slot.
- R2: Bits [23:16] of a word are a header and reach the output unchanged. Bits [15:0] are an unsigned value field.
- R3: The output value field equals the input value plus the owning card's correction. The correction for card c is taken from temp_corr[16c+15:16c] as a two's-complement number. The result saturates at 0 and at 65535.
- R4: Card c's word appears on out_word[24c+23:24c] one clock after the edge at which it was accepted. The buses of all other cards keep their previous contents.
- R5: At most one bit of out_valid is high at any time. Each accepted word raises the owning card's bit for exactly one cycle. A cycle with in_valid low produces no valid bit in the next cycle.
- R6: After the last word of the last card, the next accepted word goes to card 0, slot 0.
- R7: A synchronous reset clears out_valid and returns the counters to card 0, slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_word | input | WORD_W (24) | Incoming DAC command word |
| in_valid | input | 1 | Qualifies in_word for one cycle |
| temp_corr | input | NUM_CARDS*CORR_W | Per-card signed value correction |
| out_word | output | NUM_CARDS*WORD_W | Per-card registered corrected word |
| out_valid | output | NUM_CARDS | Per-card one-cycle valid pulse |

## Verification
The main sequence sends a full frame over four cards with unequal chip counts and zero correction. This shows whether the card boundaries fall at the configured counts and whether each word reaches the right bus. A second frame checks the wrap back to card 0, and the second frame also uses nonzero corrections. Positive, negative and extreme corrections separate plain addition from saturation at each code limit, and they also show the header staying untouched. Idle gaps between words and a reset in the middle of a frame show that only accepted words advance the counters, and that reset restarts the count at card 0.

// File: rtl/steer_demux_trim.sv
module steer_demux_trim #(
  parameter int NUM_CARDS = 4,
  parameter int WORD_W = 24,
  parameter int VAL_W = 16,
  parameter int CORR_W = 16,
  parameter int CNT_W = 8,
  parameter logic [NUM_CARDS*CNT_W-1:0] CHIP_COUNTS = {8'd3, 8'd1, 8'd4, 8'd2}
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [WORD_W-1:0]           in_word,
  input  logic                        in_valid,
  input  logic [NUM_CARDS*CORR_W-1:0] temp_corr,
  output logic [NUM_CARDS*WORD_W-1:0] out_word,
  output logic [NUM_CARDS-1:0]        out_valid
);
  localparam int CARD_IW = (NUM_CARDS > 1) ? $clog2(NUM_CARDS) : 1;
  localparam int SUM_W = ((VAL_W > CORR_W) ? VAL_W : CORR_W) + 2;
  localparam logic signed [SUM_W-1:0] MAX_S = SUM_W'({VAL_W{1'b1}});

  logic [CARD_IW-1:0] card_q;
  logic [CNT_W-1:0] slot_q;
  logic [WORD_W-1:0] out_arr [NUM_CARDS];

  logic [CNT_W-1:0] cur_chips;
  logic signed [CORR_W-1:0] cur_corr;
  logic signed [SUM_W-1:0] val_ext, corr_ext, sum;
  logic [VAL_W-1:0] trimmed;
  logic last_slot, last_card;
  logic [WORD_W-1:0] fixed_word;

  assign cur_chips = CHIP_COUNTS[int'(card_q)*CNT_W +: CNT_W];
  assign cur_corr  = temp_corr[int'(card_q)*CORR_W +: CORR_W];
  assign val_ext   = SUM_W'(in_word[VAL_W-1:0]);
  assign corr_ext  = SUM_W'(cur_corr);
  assign sum       = val_ext + corr_ext;
  assign trimmed   = (sum < 0) ? '0 : (sum > MAX_S) ? {VAL_W{1'b1}} : sum[VAL_W-1:0];
  assign fixed_word = {in_word[WORD_W-1:VAL_W], trimmed};
  assign last_slot = (slot_q == cur_chips - CNT_W'(1));
  assign last_card = (card_q == CARD_IW'(NUM_CARDS-1));

  always_ff @(posedge clk) begin
    if (rst) begin
      card_q <= '0;
      slot_q <= '0;
    end else if (in_valid) begin
      if (last_slot) begin
        slot_q <= '0;
        card_q <= last_card ? '0 : card_q + CARD_IW'(1);
      end else begin
        slot_q <= slot_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int c = 0; c < NUM_CARDS; c++) begin
      if (rst) out_valid[c] <= 1'b0;
      else out_valid[c] <= in_valid && (int'(card_q) == c);
      if (in_valid && (int'(card_q) == c)) out_arr[c] <= fixed_word;
    end
  end

  for (genvar g = 0; g < NUM_CARDS; g++) begin : g_out
    assign out_word[g*WORD_W +: WORD_W] = out_arr[g];
  end

  a_r5_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(out_valid));
  a_r5_needs_input: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (out_valid == '0));
  a_r6_wrap: assert property (@(posedge clk) disable iff (rst)
    (in_valid && last_card && last_slot) |=> (card_q == '0 && slot_q == '0));
  a_r2_header: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (out_arr[$past(card_q)][WORD_W-1:VAL_W] == $past(in_word[WORD_W-1:VAL_W])));
  a_r7_reset_clear: assert property (@(posedge clk)
    $past(rst) |-> (out_valid == '0 && card_q == '0 && slot_q == '0));
  a_r1_slot_bound: assert property (@(posedge clk) disable iff (rst)
    slot_q < cur_chips);
endmodule

// File: tb/steer_demux_trim_test.sv
module steer_demux_trim_test;
  localparam int NC = 4;
  localparam int CH [NC] = '{2, 4, 1, 3};

  logic clk = 0, rst = 1, in_valid = 0;
  logic [23:0] in_word = '0;
  logic [NC*16-1:0] temp_corr = '0;
  logic [NC*24-1:0] out_word;
  logic [NC-1:0] out_valid;
  int checks = 0, errors = 0;
  int e_card = 0, e_slot = 0;
  logic [23:0] last_out [NC];

  steer_demux_trim uut (.clk(clk), .rst(rst), .in_word(in_word), .in_valid(in_valid),
    .temp_corr(temp_corr), .out_word(out_word), .out_valid(out_valid));

  always #2 clk = ~clk;

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: run did not finish (actual hung, expected done)");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  function automatic logic [15:0] trim(input logic [15:0] v, input int corr);
    int s = int'(v) + corr;
    if (s < 0) return 16'd0;
    if (s > 65535) return 16'hFFFF;
    return 16'(s);
  endfunction

  task automatic set_corr(input int c, input int v);
    temp_corr[c*16 +: 16] = 16'(v);
  endtask

  // Sends one word and checks routing, header, trim and hold of other cards.
  task automatic send(input logic [23:0] w, input string req);
    logic [23:0] expw;
    int corr;
    @(negedge clk);
    in_word = w; in_valid = 1;
    corr = int'($signed(temp_corr[e_card*16 +: 16]));
    expw = {w[23:16], trim(w[15:0], corr)};
    @(posedge clk); #1;
    in_valid = 0;
    chk(out_valid == NC'(1 << e_card), {req, " valid route R4 R5"}, out_valid, 1 << e_card);
    chk(out_word[e_card*24 +: 24] == expw, {req, " word R2 R3"}, out_word[e_card*24 +: 24], expw);
    for (int c = 0; c < NC; c++)
      if (c != e_card)
        chk(out_word[c*24 +: 24] === last_out[c], {req, " hold R4"}, out_word[c*24 +: 24], last_out[c]);
    last_out[e_card] = expw;
    @(posedge clk); #1;
    chk(out_valid == '0, {req, " single pulse R5"}, out_valid, 0);
    if (e_slot == CH[e_card] - 1) begin
      e_slot = 0;
      e_card = (e_card == NC - 1) ? 0 : e_card + 1;
    end else e_slot++;
  endtask

  task automatic t_reset;
    rst = 1;
    repeat (2) @(posedge clk);
    #1 chk(out_valid == '0, "reset R7", out_valid, 0);
    @(negedge clk) rst = 0;
    e_card = 0; e_slot = 0;
  endtask

  task automatic t_frame;
    for (int i = 0; i < 10; i++) send({8'(8'h30 + i), 16'(16'h1000 * i + 7)}, "frame R1");
  endtask

  task automatic t_wrap;
    send(24'hA5_1234, "wrap R6");
    chk(e_card == 0, "wrap R6 model", e_card, 0);
  endtask

  task automatic t_trim;
    // e_card is 0, slot 1: finish card 0 with a positive correction
    set_corr(0, 100); set_corr(1, -50); set_corr(2, 30000); set_corr(3, -32768);
    send(24'h11_0100, "add R3");
    send(24'h22_0100, "sub R3");
    send(24'h23_0010, "floor R3");
    send(24'h24_FFFF, "sub top R3");
    send(24'h25_8000, "sub mid R3");
    send(24'h33_F000, "ceiling R3");
    send(24'h44_7000, "min corr floor R3");
    send(24'h45_FFFF, "min corr R3");
    send(24'h46_8000, "min corr zero R3");
  endtask

  task automatic t_idle;
    repeat (5) begin
      @(posedge clk); #1;
      chk(out_valid == '0, "idle R5", out_valid, 0);
    end
    send(24'h77_0042, "after idle R1");
  endtask

  task automatic t_mid_reset;
    send(24'h01_0001, "pre reset R1");
    @(negedge clk) rst = 1;
    @(negedge clk) rst = 0;
    e_card = 0; e_slot = 0;
    chk(out_valid == '0, "mid reset R7", out_valid, 0);
    send(24'h02_0002, "restart R7");
  endtask

  initial begin
    for (int c = 0; c < NC; c++) last_out[c] = 'x;
    t_reset;
    t_frame;
    t_wrap;
    t_trim;
    t_idle;
    t_mid_reset;
    repeat (3) @(posedge clk);
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule